// File: doc/BRIEF.md
# Bus-Matching Port Width Adapter

This block connects a memory with 36-bit words to an external data port that can run at 36, 18 or 9 bits. The port width is chosen at run time by two mode inputs. At full width each strobe moves one whole word. In the narrow modes a word moves as two or four beats.

On writes, the beats collect in a holding register, and one 36-bit memory write goes out after the last beat. On reads, the word is fetched once, on the first beat, and is then handed out one slice per beat. A 2-bit beat sub-counter tracks the current beat. An order input selects whether the low slice or the high slice of the word goes first.

The external bus is given as a data vector plus a per-line drive enable. The pad drivers float any line whose enable is low.

Top module: `bus_width_adapter`

## Requirements
- R1: With `bus_match` = 0, every read or write strobe moves the whole 36-bit word in one beat on lines 0..35. A write strobe raises `mem_we` in the next cycle.
- R2: With `bus_match` = 1 and `byte_size` = 0, a word moves as two 18-bit beats on lines 0..17. During read beats `port_oe` is 1 on lines 0..17 and 0 on lines 18..35.
- R3: With `bus_match` = 1 and `byte_size` = 1, a word moves as four 9-bit beats on lines 0..8. During read beats `port_oe` is 1 on lines 0..8 and 0 on lines 9..35.
- R4: With `msb_first` = 0, beat k carries word bits [k*W +: W], where W is the beat width. This holds for both reads and writes.
- R5: With `msb_first` = 1, beat k carries word bits [(N-1-k)*W +: W], where N is the number of beats per word.
- R6: A write issues exactly one memory write per word. `mem_we` is high for one cycle, in the cycle after the final beat. `mem_waddr` is the `port_addr` given with the first beat, and `mem_wdata` is the assembled word. Idle cycles between beats do not break the word.
- R7: A read asserts `mem_re`, with `mem_raddr` = `port_addr`, only on its first beat. Later beats take data from the captured word and ignore any change in `mem_rdata`.
- R8: Read data for a beat appears on `port_dout` in the cycle after its strobe. In any cycle that does not follow a read strobe, `port_oe` and `port_dout` are all zero.
- R9: A change of `bus_match`, `byte_size` or `msb_first` restarts the sub-counter, so the next strobe is beat 0 of a new word.
- R10: A strobe in the opposite direction in the middle of a word starts a new access at beat 0.
- R11: After reset, `mem_we`, `port_oe` and `port_dout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_match | input | 1 | 1 enables the narrow modes |
| byte_size | input | 1 | In narrow mode: 0 = 18-bit, 1 = 9-bit |
| msb_first | input | 1 | 0 = low slice first, 1 = high slice first |
| port_rd | input | 1 | Read beat strobe |
| port_wr | input | 1 | Write beat strobe |
| port_addr | input | ADDR_W | Word address, used on the first beat |
| port_din | input | WORD_W | External write data (low lines in the narrow modes) |
| port_dout | output | WORD_W | External read data |
| port_oe | output | WORD_W | Per-line drive enable for read data |
| mem_re | output | 1 | Memory read request |
| mem_raddr | output | ADDR_W | Memory read address |
| mem_rdata | input | WORD_W | Memory read word, same cycle as `mem_re` |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | WORD_W | Memory write word |

## Verification
The assertions check, on every cycle, the following:
- the lane-enable pattern for each width (R2, R3);
- quiet enables outside read replies (R8);
- that each memory write follows a write strobe (R6);
- single-beat writes in full-width mode (R1);
- the counter restart on a mode change without a strobe (R9).

The order of the slices is the core content of R4 and R5, and only the bench's reference model can show it. The same applies to the following:
- the assembled write word and its latched address;
- that a read ignores `mem_rdata` after its first beat;
- the restarts in the middle of a word caused by a mode change or a direction change.

// File: rtl/bus_width_adapter.sv
module bus_width_adapter #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_match,
  input  logic              byte_size,
  input  logic              msb_first,
  input  logic              port_rd,
  input  logic              port_wr,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic [WORD_W-1:0] port_din,
  output logic [WORD_W-1:0] port_dout,
  output logic [WORD_W-1:0] port_oe,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [WORD_W-1:0] mem_wdata
);
  localparam int HALF = WORD_W / 2;
  localparam int QTR  = WORD_W / 4;
  localparam logic [WORD_W-1:0] HMASK = {{(WORD_W-HALF){1'b0}}, {HALF{1'b1}}};
  localparam logic [WORD_W-1:0] QMASK = {{(WORD_W-QTR){1'b0}}, {QTR{1'b1}}};

  logic [2:0]        mode_q;
  logic [1:0]        cnt_q;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] hold_q, rd_word_q;
  logic [WORD_W-1:0] merged, rd_src, rd_slice, lanes;

  wire [2:0] mode      = {bus_match, byte_size, msb_first};
  wire       strobe    = port_rd | port_wr;
  wire       mode_chg  = mode != mode_q;
  wire       dir_chg   = strobe && (port_wr != dir_q) && (cnt_q != 2'd0);
  wire [1:0] beat      = (mode_chg || dir_chg) ? 2'd0 : cnt_q;
  wire [1:0] last      = !bus_match ? 2'd0 : (byte_size ? 2'd3 : 2'd1);
  wire       final_bt  = beat == last;
  wire [1:0] slot      = msb_first ? last - beat : beat;

  assign mem_re    = port_rd && beat == 2'd0;
  assign mem_raddr = port_addr;
  assign rd_src    = (beat == 2'd0) ? mem_rdata : rd_word_q;

  always_comb begin
    merged   = hold_q;
    rd_slice = '0;
    if (!bus_match) begin
      merged   = port_din;
      rd_slice = rd_src;
      lanes    = '1;
    end else if (!byte_size) begin
      merged[slot[0]*HALF +: HALF] = port_din[HALF-1:0];
      rd_slice[HALF-1:0]           = rd_src[slot[0]*HALF +: HALF];
      lanes                        = HMASK;
    end else begin
      merged[slot*QTR +: QTR] = port_din[QTR-1:0];
      rd_slice[QTR-1:0]       = rd_src[slot*QTR +: QTR];
      lanes                   = QMASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      cnt_q     <= '0;
      dir_q     <= 1'b0;
      addr_q    <= '0;
      hold_q    <= '0;
      rd_word_q <= '0;
      port_dout <= '0;
      port_oe   <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mode_q    <= mode;
      mem_we    <= 1'b0;
      port_dout <= '0;
      port_oe   <= '0;
      if (strobe) begin
        cnt_q <= final_bt ? 2'd0 : beat + 2'd1;
        dir_q <= port_wr;
      end else begin
        cnt_q <= beat;
      end
      if (port_wr) begin
        hold_q <= merged;
        if (beat == 2'd0) addr_q <= port_addr;
        if (final_bt) begin
          mem_we    <= 1'b1;
          mem_wdata <= merged;
          mem_waddr <= (beat == 2'd0) ? port_addr : addr_q;
        end
      end else if (port_rd) begin
        if (beat == 2'd0) rd_word_q <= mem_rdata;
        port_dout <= rd_slice;
        port_oe   <= lanes;
      end
    end
  end

  // R6
  we_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(port_wr));
  // R1
  full_single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !bus_match) |=> mem_we);
  // R2
  half_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && bus_match && !byte_size) |=> (port_oe == HMASK));
  // R3
  qtr_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && bus_match && byte_size) |=> (port_oe == QMASK));
  // R8
  quiet_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_rd |=> (port_oe == '0 && port_dout == '0));
  // R9
  mode_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !strobe) |=> (cnt_q == 2'd0));
endmodule

// File: tb/tb_bus_width_adapter.sv
`timescale 1ns/1ps
module tb_bus_width_adapter;
  logic clk = 0, rst_n = 0;
  logic match = 0, size = 0, be = 0, rd = 0, wr = 0;
  logic [14:0] addr = '0;
  logic [35:0] din = '0;
  logic [35:0] port_dout, port_oe, mem_rdata, mem_wdata;
  logic [14:0] mem_raddr, mem_waddr;
  logic mem_re, mem_we;
  logic [35:0] bmem [16];
  int vectors = 0, miscompares = 0;
  string tag = "R11";

  always #5 clk = ~clk;
  assign mem_rdata = bmem[mem_raddr[3:0]];

  bus_width_adapter dut (
    .clk(clk), .rst_n(rst_n), .bus_match(match), .byte_size(size), .msb_first(be),
    .port_rd(rd), .port_wr(wr), .port_addr(addr), .port_din(din),
    .port_dout(port_dout), .port_oe(port_oe), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  // behavioural reference
  logic [2:0] m_mode; int m_beat; bit m_dir;
  logic [35:0] m_asm, m_snap; logic [14:0] m_addr;
  logic e_we; logic [35:0] e_wd, e_dout, e_oe; logic [14:0] e_wa;

  function automatic int nbeats();
    return match ? (size ? 4 : 2) : 1;
  endfunction
  function automatic int cur_beat();
    bit chg = {match, size, be} != m_mode;
    bit dchg = (rd || wr) && (wr != m_dir) && m_beat != 0;
    return (chg || dchg) ? 0 : m_beat;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_beat = 0; m_dir = 0; m_asm = 0; m_snap = 0; m_addr = 0;
      e_we = 0; e_wd = 0; e_wa = 0; e_dout = 0; e_oe = 0;
    end else begin
      int n, w, b, s;
      n = nbeats(); w = 36 / n; b = cur_beat(); s = be ? n - 1 - b : b;
      e_we = 0; e_dout = 0; e_oe = 0;
      if (wr) begin
        if (b == 0) m_addr = addr;
        for (int i = 0; i < w; i++) m_asm[s*w+i] = din[i];
        if (b == n - 1) begin e_we = 1; e_wd = m_asm; e_wa = m_addr; end
      end else if (rd) begin
        if (b == 0) m_snap = bmem[addr[3:0]];
        for (int i = 0; i < w; i++) begin e_dout[i] = m_snap[s*w+i]; e_oe[i] = 1'b1; end
      end
      if (rd || wr) begin m_beat = (b == n - 1) ? 0 : b + 1; m_dir = wr; end
      else m_beat = b;
      m_mode = {match, size, be};
    end
  end

  task automatic check_regs();
    bit bad = 0;
    vectors++;
    if (port_oe !== e_oe) begin bad = 1;
      $display("FAIL %s port_oe act=%h exp=%h", tag, port_oe, e_oe); end
    if (port_dout !== e_dout) begin bad = 1;
      $display("FAIL %s port_dout act=%h exp=%h", tag, port_dout, e_dout); end
    if (mem_we !== e_we) begin bad = 1;
      $display("FAIL %s mem_we act=%b exp=%b", tag, mem_we, e_we); end
    if (e_we && (mem_wdata !== e_wd || mem_waddr !== e_wa)) begin bad = 1;
      $display("FAIL %s mem write act=%h@%h exp=%h@%h", tag, mem_wdata, mem_waddr, e_wd, e_wa); end
    if (bad) miscompares++;
  endtask

  task automatic check_comb();
    bit exp_re = rd && cur_beat() == 0;
    vectors++;
    if (mem_re !== exp_re || (exp_re && mem_raddr !== addr)) begin
      miscompares++;
      $display("FAIL %s mem_re act=%b@%h exp=%b@%h", tag, mem_re, mem_raddr, exp_re, addr);
    end
  endtask

  task automatic step(input bit r, input bit w, input logic [14:0] a, input logic [35:0] d);
    @(negedge clk);
    check_regs();
    rd = r; wr = w; addr = a; din = d;
    #2 check_comb();
  endtask

  task automatic set_mode(input bit m, input bit s, input bit e);
    @(negedge clk); check_regs(); rd = 0; wr = 0; match = m; size = s; be = e;
  endtask

  task automatic write_word(input logic [14:0] a, input logic [35:0] word, input bit gaps);
    int n = nbeats(); int w = 36 / n;
    for (int k = 0; k < n; k++) begin
      int s = be ? n - 1 - k : k;
      step(0, 1, (k == 0) ? a : a + 15'd7, (word >> (s * w)) & ((36'd1 << w) - 36'd1));
      if (gaps) step(0, 0, 0, 0);
    end
  endtask

  task automatic read_word(input logic [14:0] a);
    for (int k = 0; k < nbeats(); k++) step(1, 0, a, 0);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = 36'h123456789 ^ (36'h0F0F0F0F1 * i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tag = "R11"; step(0, 0, 0, 0); step(0, 0, 0, 0);
    tag = "R1";  set_mode(0, 0, 0);
    write_word(15'd3, 36'h9ABCDEF01, 0); write_word(15'd4, 36'h000000FFF, 0);
    read_word(15'd5); read_word(15'd6); step(0, 0, 0, 0);
    tag = "R2,R4"; set_mode(1, 0, 0);
    write_word(15'd1, 36'hA5A5C3C3F, 0); read_word(15'd2); read_word(15'd9);
    tag = "R2,R5"; set_mode(1, 0, 1);
    write_word(15'd2, 36'h13579BDF0, 0); read_word(15'd2); read_word(15'd10);
    tag = "R3,R4"; set_mode(1, 1, 0);
    write_word(15'd11, 36'hFEDCBA987, 0); read_word(15'd11); read_word(15'd12);
    tag = "R3,R5"; set_mode(1, 1, 1);
    write_word(15'd13, 36'h0123456AB, 0); read_word(15'd13); read_word(15'd14);
    tag = "R6"; write_word(15'd5, 36'h8C8C8C8C8, 1);
    set_mode(1, 0, 0); write_word(15'd6, 36'h7E7E7E7E7, 1);
    tag = "R7"; set_mode(1, 1, 0);
    step(1, 0, 15'd8, 0);
    @(negedge clk); bmem[8] = 36'hDEADBEEF5; check_regs(); rd = 1; #2 check_comb();
    step(1, 0, 15'd8, 0); step(1, 0, 15'd8, 0);
    tag = "R8"; step(0, 0, 0, 0); step(0, 0, 0, 0);
    tag = "R9"; step(0, 1, 15'd3, 36'h1AA);
    set_mode(1, 1, 1); write_word(15'd3, 36'h55AA55AA5, 0);
    step(1, 0, 15'd4, 0); set_mode(1, 0, 1); read_word(15'd4);
    tag = "R10"; set_mode(1, 1, 0);
    step(0, 1, 15'd7, 36'h0FF); step(0, 1, 15'd7, 36'h011);
    read_word(15'd7); step(1, 0, 15'd9, 0); write_word(15'd9, 36'h3C3C3C3C3, 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule